// File: doc/BRIEF.md
# Satellite Control Envelope Bit Transmitter

This block serialises a satellite-equipment control command onto a single envelope output. A high output gates an external 22 kHz carrier on, and a low output gates it off. The carrier itself is generated elsewhere. A command is a short list of bytes. Each byte goes out most significant bit first and is followed by an odd-parity bit. Each bit is pulse-width coded as a high segment followed by a low segment. The whole message sits between two silent guard intervals. After the trailing guard, an optional satellite-select burst can follow: either a steady carrier tone, or a modulated 0xFF byte. A fixed settle interval closes the burst.

All timing comes from a unit of 500 µs, called a tick. A prescaler builds the tick from the system clock, so every segment is an exact multiple of `CLKS_PER_TICK` clock cycles. The user presents the message bytes, a length and a burst code, then pulses `start`. The block copies these inputs when it accepts the start, and holds `busy` high until the final low interval ends. While the block is idle, the output follows a continuous-tone request input.

Top module: `dsq_env_tx`

## Requirements
- R1: A bit of value 1 is 1 tick high then 2 ticks low. A bit of value 0 is 2 ticks high then 1 tick low. Every output change during a transmission falls on a tick boundary, and one tick is `CLKS_PER_TICK` clock cycles.
- R2: Bytes go out in order, starting with byte 0 in `msg_data[7:0]`, then byte k in `msg_data[8k+7:8k]`. Each byte goes MSB first and is followed by a ninth bit equal to 1 XOR all eight data bits, so each 9-bit group has odd parity.
- R3: The output is low for 32 ticks before the first data bit. After the low segment of the last bit it stays low for a further 32 ticks. A length of 0 therefore gives 64 low ticks, followed only by the selected burst.
- R4: `burst_sel` is decoded as follows. Code 2'b01 gives 25 ticks high then 40 ticks low. Code 2'b10 sends byte 0xFF with the normal coding and parity, then 40 ticks low. Codes 2'b00 and 2'b11 add nothing after the trailing guard.
- R5: `busy` is high from the clock edge that samples an accepted `start`. It falls at the edge that ends the last low segment, so the busy time equals the total tick count of the sequence times `CLKS_PER_TICK`.
- R6: A `start` while busy is ignored. The message, length and burst code are captured when `start` is accepted, so changing these inputs during a transmission has no effect on the output.
- R7: While idle, `env_out` equals the value `tone_en` had at the previous clock edge. While busy, `tone_en` has no effect on `env_out`.
- R8: A `msg_len` greater than `MAX_BYTES` is treated as `MAX_BYTES`.
- R9: During reset, `busy` and `env_out` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transmission |
| msg_len | input | $clog2(MAX_BYTES+1) | Number of message bytes to send |
| msg_data | input | 8*MAX_BYTES | Message bytes, byte 0 in the low 8 bits |
| burst_sel | input | 2 | Burst code sent after the trailing guard |
| tone_en | input | 1 | Continuous-tone request used while idle |
| env_out | output | 1 | Carrier gate envelope |
| busy | output | 1 | High while a sequence is in progress |

## Verification
The bench builds the block with `CLKS_PER_TICK` = 4 and `MAX_BYTES` = 6. This keeps even a full six-byte message with a modulated burst to roughly twelve hundred cycles, so every segment length is measured in exact cycles. With six bytes of input storage, a length code of 7 is available on the 3-bit length port, which exercises the clamp. Long messages, both burst kinds and the reserved burst code all fit well inside the run.

// File: rtl/dsq_env_pkg.sv
// Shared types for the envelope transmitter.
// Assumes: the burst code is 2 bits wide and bytes are 8 bits wide.
package dsq_env_pkg;

    localparam int DATA_BITS = 8;

    // Byte value sent as the modulated select burst
    localparam logic [DATA_BITS-1:0] BURST_BYTE_VAL = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MARK,
        ST_SPACE,
        ST_TRAIL,
        ST_TONE,
        ST_SETTLE
    } tx_state_e;

    typedef enum logic [1:0] {
        BURST_OFF  = 2'b00,
        BURST_TONE = 2'b01,
        BURST_BYTE = 2'b10,
        BURST_RSVD = 2'b11
    } burst_e;

endpackage

// File: rtl/dsq_tick_gen.sv
// Tick prescaler: while en is high, it emits a one-cycle tick every
// CLKS_PER_TICK clocks. The first tick comes CLKS_PER_TICK clocks after en rises.
// Assumes: en is low in idle, so every transmission starts from a zero count.
module dsq_tick_gen #(
    parameter int CLKS_PER_TICK = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

    logic [PW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Count clocks within one tick; hold at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dsq_seg_timer.sv
// Segment timer: it is loaded with a length in ticks, and raises done
// combinationally on the tick that completes the segment.
// Assumes: load_ticks is at least 1. A load in the same cycle as done
// starts the next segment seamlessly.
module dsq_seg_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_ticks,
    input  logic          tick,
    output logic          done
);
    logic [TW-1:0] left_q;

    assign done = tick && (left_q == TW'(1));

    // Track ticks remaining in the current segment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_ticks;
        end else if (tick && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/dsq_byte_ser.sv
// Byte serialiser: it presents the data bits MSB first and then an odd-parity
// bit. Parity starts at 1 and absorbs every data bit as it is shifted out.
// Assumes: shift is ignored once the parity bit is presented (last_o high).
module dsq_byte_ser
    import dsq_env_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 shift,
    output logic                 bit_o,
    output logic                 last_o
);
    localparam int IW = $clog2(DATA_BITS + 1);

    logic [DATA_BITS-1:0] sh_q;
    logic                 par_q;
    logic [IW-1:0]        idx_q;

    assign last_o = (idx_q == IW'(DATA_BITS));
    assign bit_o  = last_o ? par_q : sh_q[DATA_BITS-1];

    // Hold the byte, its running parity and the bit position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b1;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            par_q <= 1'b1;
            idx_q <= '0;
        end else if (shift && !last_o) begin
            par_q <= par_q ^ sh_q[DATA_BITS-1];
            sh_q  <= sh_q << 1;
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/dsq_env_tx.sv
// Envelope transmitter top. It sequences the lead guard, the coded bits of
// each byte, the trailing guard and the optional burst with its settle time.
// Assumes: msg_data is valid in the start cycle only. All durations are in
// ticks of CLKS_PER_TICK clocks.
module dsq_env_tx
    import dsq_env_pkg::*;
#(
    parameter int CLKS_PER_TICK = 50000,
    parameter int MAX_BYTES     = 6,
    parameter int SHORT_TICKS   = 1,
    parameter int LONG_TICKS    = 2,
    parameter int GUARD_TICKS   = 32,
    parameter int TONE_TICKS    = 25,
    parameter int SETTLE_TICKS  = 40,
    localparam int LEN_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LEN_W-1:0]          msg_len,
    input  logic [8*MAX_BYTES-1:0]    msg_data,
    input  logic [1:0]                burst_sel,
    input  logic                      tone_en,
    output logic                      env_out,
    output logic                      busy
);
    localparam int MAX_A = (GUARD_TICKS > TONE_TICKS) ? GUARD_TICKS : TONE_TICKS;
    localparam int MAX_B = (SETTLE_TICKS > LONG_TICKS) ? SETTLE_TICKS : LONG_TICKS;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXT + 1);

    localparam logic [TW-1:0] T_SHORT  = TW'(SHORT_TICKS);
    localparam logic [TW-1:0] T_LONG   = TW'(LONG_TICKS);
    localparam logic [TW-1:0] T_GUARD  = TW'(GUARD_TICKS);
    localparam logic [TW-1:0] T_TONE   = TW'(TONE_TICKS);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_TICKS);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

    tx_state_e             st_q, st_n;
    logic [8*MAX_BYTES-1:0] msg_q;
    logic [LEN_W-1:0]      len_q, ptr_q, ptr_n;
    burst_e                burst_q;
    logic                  bit_q, bit_n, last_q, last_n, more_q, more_n;
    logic                  inb_q, inb_n, env_q, env_n;

    logic                  tick_w, seg_done;
    logic                  tm_load;
    logic [TW-1:0]         tm_val;
    logic                  ser_load, ser_shift, ser_bit, ser_last;
    logic [DATA_BITS-1:0]  ser_din, nxt_byte;
    logic                  nxt_ok, go_mark, go_trail, go_end;

    assign busy    = (st_q != ST_IDLE);
    assign env_out = env_q;

    dsq_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick_w)
    );

    dsq_seg_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .load_ticks(tm_val),
        .tick(tick_w), .done(seg_done)
    );

    dsq_byte_ser u_ser (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .din(ser_din),
        .shift(ser_shift), .bit_o(ser_bit), .last_o(ser_last)
    );

    // Pick the byte after the current one and flag whether one remains
    always_comb begin
        nxt_byte = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (i == int'(ptr_q) + 1) nxt_byte = msg_q[8*i +: 8];
        end
        nxt_ok = ({1'b0, ptr_q} + 1'b1) < {1'b0, len_q};
    end

    // Next-state, segment loading and serialiser control
    always_comb begin
        st_n      = st_q;
        env_n     = env_q;
        bit_n     = bit_q;
        last_n    = last_q;
        more_n    = more_q;
        inb_n     = inb_q;
        ptr_n     = ptr_q;
        tm_load   = 1'b0;
        tm_val    = T_GUARD;
        ser_load  = 1'b0;
        ser_shift = 1'b0;
        ser_din   = msg_data[7:0];
        go_mark   = 1'b0;
        go_trail  = 1'b0;
        go_end    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                env_n = tone_en;
                if (start) begin
                    st_n     = ST_LEAD;
                    tm_load  = 1'b1;
                    tm_val   = T_GUARD;
                    ser_load = 1'b1;
                    env_n    = 1'b0;
                    inb_n    = 1'b0;
                    ptr_n    = '0;
                end
            end
            ST_LEAD: begin
                if (seg_done) begin
                    if (len_q != '0) go_mark = 1'b1;
                    else             go_trail = 1'b1;
                end
            end
            ST_MARK: begin
                if (seg_done) begin
                    st_n    = ST_SPACE;
                    tm_load = 1'b1;
                    tm_val  = bit_q ? T_LONG : T_SHORT;
                    env_n   = 1'b0;
                end
            end
            ST_SPACE: begin
                if (seg_done) begin
                    if (!last_q || more_q) begin
                        go_mark = 1'b1;
                    end else if (inb_q) begin
                        st_n    = ST_SETTLE;
                        tm_load = 1'b1;
                        tm_val  = T_SETTLE;
                        env_n   = 1'b0;
                    end else begin
                        go_trail = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (seg_done) begin
                    case (burst_q)
                        BURST_TONE: begin
                            st_n    = ST_TONE;
                            tm_load = 1'b1;
                            tm_val  = T_TONE;
                            env_n   = 1'b1;
                        end
                        BURST_BYTE: begin
                            inb_n   = 1'b1;
                            go_mark = 1'b1;
                        end
                        default: go_end = 1'b1;
                    endcase
                end
            end
            ST_TONE: begin
                if (seg_done) begin
                    st_n    = ST_SETTLE;
                    tm_load = 1'b1;
                    tm_val  = T_SETTLE;
                    env_n   = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (seg_done) go_end = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase

        if (go_mark) begin
            st_n    = ST_MARK;
            tm_load = 1'b1;
            tm_val  = ser_bit ? T_SHORT : T_LONG;
            env_n   = 1'b1;
            bit_n   = ser_bit;
            last_n  = ser_last;
            more_n  = 1'b0;
            if (ser_last) begin
                if (!inb_n && nxt_ok) begin
                    ser_load = 1'b1;
                    ser_din  = nxt_byte;
                    ptr_n    = ptr_q + 1'b1;
                    more_n   = 1'b1;
                end
            end else begin
                ser_shift = 1'b1;
            end
        end
        if (go_trail) begin
            st_n    = ST_TRAIL;
            tm_load = 1'b1;
            tm_val  = T_GUARD;
            env_n   = 1'b0;
            if (burst_q == BURST_BYTE) begin
                ser_load = 1'b1;
                ser_din  = BURST_BYTE_VAL;
            end
        end
        if (go_end) begin
            st_n  = ST_IDLE;
            env_n = tone_en;
        end
    end

    // Sequencer state, output register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            env_q   <= 1'b0;
            bit_q   <= 1'b0;
            last_q  <= 1'b0;
            more_q  <= 1'b0;
            inb_q   <= 1'b0;
            ptr_q   <= '0;
            len_q   <= '0;
            msg_q   <= '0;
            burst_q <= BURST_OFF;
        end else begin
            st_q   <= st_n;
            env_q  <= env_n;
            bit_q  <= bit_n;
            last_q <= last_n;
            more_q <= more_n;
            inb_q  <= inb_n;
            ptr_q  <= ptr_n;
            if (st_q == ST_IDLE && start) begin
                msg_q   <= msg_data;
                len_q   <= (msg_len > LEN_MAX) ? LEN_MAX : msg_len;
                burst_q <= burst_e'(burst_sel);
            end
        end
    end
endmodule

// File: rtl/dsq_env_tx_chk.sv
// Protocol checker for the envelope transmitter, attached by bind.
// Assumes: tick is the prescaler pulse inside the top module.
module dsq_env_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic env_out,
    input logic tone_en,
    input logic tick
);
    logic armed;

    // Becomes set one edge after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !env_out));

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    idle_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !busy && !$past(busy)) |-> (env_out == $past(tone_en)));

    // R3
    lead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !env_out);

    // R3
    tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(env_out));

    // R1
    tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (env_out != $past(env_out))) |-> $past(tick));
endmodule

bind dsq_env_tx dsq_env_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .env_out(env_out), .tone_en(tone_en), .tick(tick_w)
);

// File: tb/dsq_env_tx_bench.sv
`timescale 1ns/1ps
module dsq_env_tx_bench;
    localparam int CPT = 4;
    localparam int NB  = 6;

    typedef struct packed {
        logic [2:0]  len;
        logic [1:0]  burst;
        logic [47:0] data;
    } vec_t;

    // Stimulus table: length, burst code, bytes (byte 0 lowest)
    localparam vec_t VECS [6] = '{
        '{3'd3, 2'b00, 48'h0000_0038_10E0},
        '{3'd0, 2'b01, 48'h0000_0000_0000},
        '{3'd0, 2'b10, 48'h0000_0000_0000},
        '{3'd4, 2'b01, 48'h0000_0F6B_31E0},
        '{3'd1, 2'b11, 48'h0000_0000_0000},
        '{3'd2, 2'b10, 48'h0000_0000_A5FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  msg_len = '0;
    logic [47:0] msg_data = '0;
    logic [1:0]  burst_sel = '0;
    logic        tone_en = 1'b0;
    logic        env_out, busy;

    int n_chk = 0, n_fail = 0;
    int exp_lvl[256], exp_len[256], got_lvl[256], got_len[256];
    int exp_bits[128], dec_bits[128];
    int exp_n, exp_nb, exp_total, got_n, got_total;

    always #2 clk = ~clk;

    dsq_env_tx #(.CLKS_PER_TICK(CPT), .MAX_BYTES(NB)) u_dsq_env_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
        .msg_data(msg_data), .burst_sel(burst_sel), .tone_en(tone_en),
        .env_out(env_out), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic exp_push(input int lvl, input int ticks);
        if (exp_n > 0 && exp_lvl[exp_n-1] == lvl) begin
            exp_len[exp_n-1] += ticks * CPT;
        end else begin
            exp_lvl[exp_n] = lvl;
            exp_len[exp_n] = ticks * CPT;
            exp_n++;
        end
        exp_total += ticks * CPT;
    endtask

    task automatic exp_bit(input int b);
        exp_push(1, (b != 0) ? 1 : 2);
        exp_push(0, (b != 0) ? 2 : 1);
        exp_bits[exp_nb] = b;
        exp_nb++;
    endtask

    task automatic exp_byte(input logic [7:0] v);
        int p = 1;
        for (int i = 7; i >= 0; i--) begin
            p ^= int'(v[i]);
            exp_bit(int'(v[i]));
        end
        exp_bit(p);
    endtask

    // Expected waveform, built from the requirements
    task automatic build_exp(input int len, input logic [47:0] data, input logic [1:0] burst);
        exp_n = 0; exp_nb = 0; exp_total = 0;
        if (len > NB) len = NB;
        exp_push(0, 32);
        for (int k = 0; k < len; k++) exp_byte(data[8*k +: 8]);
        exp_push(0, 32);
        if (burst == 2'b01) begin
            exp_push(1, 25);
            exp_push(0, 40);
        end else if (burst == 2'b10) begin
            exp_byte(8'hFF);
            exp_push(0, 40);
        end
    endtask

    // Start a transmission and record the output runs while busy
    task automatic run_capture(input logic [2:0] len, input logic [47:0] data,
                               input logic [1:0] burst, input bit disturb);
        int cur, cnt, cyc;
        @(negedge clk);
        msg_len = len; msg_data = data; burst_sel = burst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
        got_n = 0; got_total = 0; cur = int'(env_out); cnt = 0; cyc = 0;
        while (busy && cyc < 20000) begin
            if (int'(env_out) == cur) begin
                cnt++;
            end else begin
                if (got_n < 256) begin got_lvl[got_n] = cur; got_len[got_n] = cnt; end
                got_n++;
                cur = int'(env_out);
                cnt = 1;
            end
            cyc++;
            if (disturb && cyc == 5) begin
                msg_data = ~data; msg_len = 3'd1; burst_sel = 2'b01;
                tone_en = 1'b1; start = 1'b1;
            end
            if (disturb && cyc == 6) start = 1'b0;
            @(negedge clk);
        end
        if (got_n < 256) begin got_lvl[got_n] = cur; got_len[got_n] = cnt; end
        got_n++;
        got_total = cyc;
    endtask

    // Compare runs, decode bits and check the busy length
    task automatic judge(input string tag);
        int a, e, nb, bad, b;
        bit ok;
        ok = (got_n == exp_n); a = got_n; e = exp_n;
        if (ok) begin
            for (int i = 0; i < got_n; i++) begin
                if (ok && (got_lvl[i] != exp_lvl[i] || got_len[i] != exp_len[i])) begin
                    ok = 1'b0; a = got_len[i]; e = exp_len[i];
                end
            end
        end
        chk(ok, "R1 R3 R4", {tag, " segment runs"}, a, e);

        nb = 0; bad = 0;
        for (int i = 0; i < got_n; i++) begin
            if (got_lvl[i] == 1) begin
                if (got_len[i] == CPT) b = 1;
                else if (got_len[i] == 2*CPT) b = 0;
                else if (got_len[i] == 25*CPT) continue;
                else begin bad++; continue; end
                if (nb < 128) dec_bits[nb] = b;
                nb++;
            end
        end
        ok = (bad == 0) && (nb == exp_nb);
        for (int i = 0; i < nb && i < 128 && ok; i++) if (dec_bits[i] != exp_bits[i]) ok = 1'b0;
        for (int g = 0; g + 9 <= nb && ok; g += 9) begin
            int p = 0;
            for (int j = 0; j < 9; j++) p ^= dec_bits[g+j];
            if (p != 1) ok = 1'b0;
        end
        chk(ok, "R2", {tag, " decoded bits and odd parity"}, nb, exp_nb);

        chk(got_total == exp_total, "R5", {tag, " busy cycles"}, got_total, exp_total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R9: reset state with tone requested
        tone_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
        chk(env_out == 1'b0, "R9", "env_out in reset", int'(env_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(env_out == 1'b1, "R7", "idle follows tone on", int'(env_out), 1);
        tone_en = 1'b0;
        @(negedge clk);
        chk(env_out == 1'b0, "R7", "idle follows tone off", int'(env_out), 0);

        // Table of vectors
        for (int v = 0; v < 6; v++) begin
            build_exp(int'(VECS[v].len), VECS[v].data, VECS[v].burst);
            run_capture(VECS[v].len, VECS[v].data, VECS[v].burst, 1'b0);
            judge($sformatf("vector %0d", v));
            repeat (3) @(negedge clk);
        end

        // R8: length above capacity is clamped
        build_exp(7, 48'hC3_5A_81_7E_24_99, 2'b00);
        run_capture(3'd7, 48'hC3_5A_81_7E_24_99, 2'b00, 1'b0);
        judge("R8 clamp");
        repeat (3) @(negedge clk);

        // R6 R7: inputs, start and tone changed while busy
        build_exp(2, 48'h0000_0000_3412, 2'b10);
        run_capture(3'd2, 48'h0000_0000_3412, 2'b10, 1'b1);
        judge("R6 R7 disturbed");
        chk(env_out == 1'b1, "R7", "tone resumes at end", int'(env_out), 1);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R6", "ignored start left no run", int'(busy), 0);
        tone_en = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule